// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter, four bits wide by default, whose state changes only on the rising clock edge. Each edge does one of three things to the count: it loads a parallel preset word, it adds one, or it keeps the value. Two active-low controls select the action, and the load control wins over the count control. An active-high master reset clears the count. The reset takes effect at once, and its release is synchronised to the clock.

The block drives an active-low terminal-count flag. The flag is decoded from the counter state and the count enable, so no register sits in its path. Wider counters are built by chaining stages: the flag of each stage drives the count enable of the stage above it. The whole chain then advances as one binary counter. A flag that feeds back into the load control gives a reload at close to full counting speed.

Top module: `preset_counter`

## Requirements
- R1: While `mr` is high, `q` reads zero and `tc_n` reads high, whatever `pe_n`, `cen_n` and `pdata` are doing and without waiting for a clock edge.
- R2: After `mr` falls, the count stays at zero through the next two rising edges. The first load or count takes effect on the third rising edge.
- R3: A rising edge with `pe_n` low copies `pdata` into `q`, whether `cen_n` is high or low.
- R4: A rising edge with `pe_n` high and `cen_n` low adds one to `q`, modulo 2^WIDTH, so all ones becomes zero.
- R5: A rising edge with both `pe_n` and `cen_n` high leaves `q` unchanged, and `pdata` has no effect on it.
- R6: `tc_n` is low exactly when `q` is all ones and `cen_n` is low. It follows `cen_n` without a clock edge and is high in every other case.
- R7: `mr` overrides load and count: with `mr` high, edges that carry `pe_n` low or `cen_n` low leave `q` at zero.
- R8: Two stages, with the `tc_n` of the lower one wired to the `cen_n` of the upper one, count as one 2*WIDTH-bit binary counter. This holds through loads, holds and the carry from the low stage into the high stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mr | input | 1 | Master reset, active high, asserts asynchronously |
| pdata | input | WIDTH | Preset word that a load copies into the count |
| pe_n | input | 1 | Parallel load enable, active low |
| cen_n | input | 1 | Count enable, active low |
| q | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low, cascade output |

## Verification
The bench drives the count through the all-ones to zero wrap. A design with a wrong adder width or a saturating count stops at fifteen or goes to a wrong value there. It drives load and count enable low on the same edge, so an inverted priority shows up as an increment where a load was expected. It moves `cen_n` with the count held at all ones and watches `tc_n` between edges; a flag that is registered, or that ignores the enable, lags one cycle or stays low. In an 8-bit chain it counts across several carries from the low nibble into the high one and compares each step with a model. It also counts the edges after reset release, which catches a release that takes effect too early or too late.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } pc_op_e;
endpackage

// File: rtl/pc_rst_sync.sv
// Master reset: asserts at once, releases after STAGES rising edges.
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic mr,
  output logic rst_q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b0};
  end

  always_ff @(posedge clk or posedge mr) begin
    if (mr) sr_q <= '1;
    else    sr_q <= sr_d;
  end

  assign rst_q = sr_q[STAGES-1];

  assert_rst_follows_mr_R1: assert property (@(posedge clk) mr |-> rst_q)
    else $error("internal reset low while mr high");
endmodule

// File: rtl/pc_next.sv
// Operation select (load over count over hold) and next-count value.
module pc_next
  import pc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] pdata,
  input  logic             pe_n,
  input  logic             cen_n,
  output pc_op_e           op,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    if (!pe_n)       op = OP_LOAD;
    else if (!cen_n) op = OP_COUNT;
    else             op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_LOAD:  nxt = pdata;
      OP_COUNT: nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/pc_tc.sv
// Terminal-count decode: pure logic, no register in the cascade path.
module pc_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             cen_n,
  input  logic             rst,
  output logic             tc_n
);
  logic all_ones;

  always_comb begin
    all_ones = &cur;
    tc_n     = ~(all_ones & ~cen_n & ~rst);
  end
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import pc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mr,
  input  logic [WIDTH-1:0] pdata,
  input  logic             pe_n,
  input  logic             cen_n,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             rst_q;
  pc_op_e           op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  pc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk  (clk),
    .mr   (mr),
    .rst_q(rst_q)
  );

  pc_next #(.WIDTH(WIDTH)) u_next (
    .cur  (cnt_q),
    .pdata(pdata),
    .pe_n (pe_n),
    .cen_n(cen_n),
    .op   (op),
    .nxt  (cnt_d)
  );

  always_comb begin
    cnt_en = (op != OP_HOLD);
  end

  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q)       cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  pc_tc #(.WIDTH(WIDTH)) u_tc (
    .cur  (cnt_q),
    .cen_n(cen_n),
    .rst  (rst_q),
    .tc_n (tc_n)
  );

  assign q = cnt_q;

  assert_reset_clears_R1: assert property (@(posedge clk) mr |-> (q == '0 && tc_n))
    else $error("count or terminal count not cleared under reset");

  assert_load_R3: assert property (@(posedge clk) disable iff (rst_q)
      (!rst_q && !pe_n) |=> (q == $past(pdata)))
    else $error("load did not copy preset word");

  assert_count_R4: assert property (@(posedge clk) disable iff (rst_q)
      (!rst_q && pe_n && !cen_n) |=> (q == $past(q) + ONE))
    else $error("count did not advance by one");

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst_q)
      (!rst_q && pe_n && cen_n) |=> $stable(q))
    else $error("count moved while held");

  assert_tc_full_R6: assert property (@(posedge clk) disable iff (rst_q)
      (!tc_n) |-> (q == '1 && !cen_n))
    else $error("terminal count low away from all ones");
endmodule

// File: tb/preset_counter_test.sv
module preset_counter_test;
  logic       clk;
  logic       mr;
  logic [3:0] pdata;
  logic       pe_n;
  logic       cen_n;
  logic [3:0] q;
  logic       tc_n;

  logic [3:0] c_pdata_lo, c_pdata_hi;
  logic       c_pe_n, c_cen_n;
  logic [3:0] c_q_lo, c_q_hi;
  logic       c_tc_lo, c_tc_hi;

  int total = 0;
  int bad   = 0;

  preset_counter uut (
    .clk(clk), .mr(mr), .pdata(pdata), .pe_n(pe_n), .cen_n(cen_n),
    .q(q), .tc_n(tc_n)
  );

  preset_counter stage_lo (
    .clk(clk), .mr(mr), .pdata(c_pdata_lo), .pe_n(c_pe_n), .cen_n(c_cen_n),
    .q(c_q_lo), .tc_n(c_tc_lo)
  );

  preset_counter stage_hi (
    .clk(clk), .mr(mr), .pdata(c_pdata_hi), .pe_n(c_pe_n), .cen_n(c_tc_lo),
    .q(c_q_hi), .tc_n(c_tc_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    mr = 1'b1; pe_n = 1'b1; cen_n = 1'b1; pdata = 4'd0;
    c_pe_n = 1'b1; c_cen_n = 1'b1; c_pdata_lo = 4'd0; c_pdata_hi = 4'd0;
    repeat (3) tick();
    check("R1 reset q", int'(q), 0);
    check("R1 reset tc_n", int'(tc_n), 1);
    mr = 1'b0;
    repeat (3) tick();
  endtask

  task automatic test_release_r2();
    mr = 1'b1; pe_n = 1'b1; cen_n = 1'b0;
    tick();
    mr = 1'b0;
    tick();
    check("R2 first edge after release", int'(q), 0);
    tick();
    check("R2 second edge after release", int'(q), 0);
    tick();
    check("R2 third edge counts", int'(q), 1);
    cen_n = 1'b1;
  endtask

  task automatic test_load_r3();
    pe_n = 1'b0; cen_n = 1'b1; pdata = 4'd9;
    tick();
    check("R3 load with count off", int'(q), 9);
    cen_n = 1'b0; pdata = 4'd5;
    tick();
    check("R3 load beats count", int'(q), 5);
    pe_n = 1'b1; cen_n = 1'b1;
  endtask

  task automatic test_count_r4();
    pe_n = 1'b0; cen_n = 1'b1; pdata = 4'd13;
    tick();
    pe_n = 1'b1; cen_n = 1'b0;
    tick(); check("R4 13->14", int'(q), 14);
    tick(); check("R4 14->15", int'(q), 15);
    tick(); check("R4 wrap 15->0", int'(q), 0);
    tick(); check("R4 0->1", int'(q), 1);
    cen_n = 1'b1;
  endtask

  task automatic test_hold_r5();
    pe_n = 1'b1; cen_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pdata = 4'(i + 6);
      tick();
      check("R5 hold ignores pdata", int'(q), 1);
    end
  endtask

  task automatic test_tc_r6();
    pe_n = 1'b0; cen_n = 1'b1; pdata = 4'd15;
    tick();
    pe_n = 1'b1;
    #1 check("R6 full, count off", int'(tc_n), 1);
    cen_n = 1'b0;
    #1 check("R6 full, count on", int'(tc_n), 0);
    cen_n = 1'b1;
    #1 check("R6 follows enable back high", int'(tc_n), 1);
    pe_n = 1'b0; pdata = 4'd14;
    tick();
    pe_n = 1'b1; cen_n = 1'b0;
    #1 check("R6 fourteen not terminal", int'(tc_n), 1);
    cen_n = 1'b1;
  endtask

  task automatic test_prio_r7();
    pe_n = 1'b0; pdata = 4'd15;
    tick();
    pe_n = 1'b1; cen_n = 1'b0;
    #1;
    mr = 1'b1; pe_n = 1'b0; pdata = 4'd7;
    #1 check("R1 async clear q", int'(q), 0);
    check("R1 async tc_n high", int'(tc_n), 1);
    tick(); check("R7 load blocked", int'(q), 0);
    pe_n = 1'b1;
    tick(); check("R7 count blocked", int'(q), 0);
    cen_n = 1'b1; mr = 1'b0;
    repeat (3) tick();
  endtask

  task automatic test_cascade_r8();
    logic [7:0] model;
    c_pe_n = 1'b0; c_cen_n = 1'b1; c_pdata_lo = 4'hD; c_pdata_hi = 4'h2;
    tick();
    model = 8'h2D;
    check("R8 chain load", int'({c_q_hi, c_q_lo}), int'(model));
    c_pe_n = 1'b1; c_cen_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      model = model + 8'd1;
      check("R8 chain count", int'({c_q_hi, c_q_lo}), int'(model));
    end
    c_cen_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8 chain hold", int'({c_q_hi, c_q_lo}), int'(model));
    end
    c_pe_n = 1'b0; c_pdata_lo = 4'hE; c_pdata_hi = 4'hF;
    tick();
    c_pe_n = 1'b1; c_cen_n = 1'b0;
    model = 8'hFE;
    for (int i = 0; i < 4; i++) begin
      tick();
      model = model + 8'd1;
      check("R8 chain wrap", int'({c_q_hi, c_q_lo}), int'(model));
    end
    c_cen_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    test_release_r2();
    test_load_r3();
    test_count_r4();
    test_hold_r5();
    test_tc_r6();
    test_prio_r7();
    test_cascade_r8();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule